// File: doc/BRIEF.md
# NRU Page Victim Selector

This block keeps, for every one of `FRAMES` resident page frames, a present flag, a referenced bit and a modified bit, and names a frame to evict when asked. Read and write accesses mark frames as used. A periodic tick wipes every referenced bit so that "recently used" means "used since the last tick". The dirty state of each frame survives the tick.

On a victim request, every present frame is ranked by the two-bit class `{referenced, modified}`. The chosen frame comes from the lowest class that has at least one present member. Within that class a free-running 16-bit LFSR supplies a start position, and the first member at or after that position is taken, with the search wrapping around. The answer is registered and is flagged valid in the cycle after the request.

A small two-state machine sequences the reply. In `ST_IDLE` no reply is pending. A request moves it to `ST_REPLY` (transition `REQ_ACCEPT`). It stays in `ST_REPLY` on a back-to-back request (`REQ_AGAIN`) and returns to `ST_IDLE` when there is no request (`REPLY_DONE`).

Top module: `nru_victim_sel`

## Requirements
- R1: After reset no frame is present, all referenced and modified bits are 0, `none_res` is 1 and `vic_vld` is 0.
- R2: `frame_ld` with `frame_idx` makes that frame present with referenced=1 and modified=0. In the same cycle, a load takes priority over a read or write strobe on that frame.
- R3: `acc_rd` sets only the referenced bit of `frame_idx`. `acc_wr` sets both the referenced and the modified bit.
- R4: The class of a frame is the two-bit value {referenced, modified}, with 0 the lowest and 3 the highest. The victim always belongs to the lowest class that has a present member.
- R5: Within the target class, the victim is the first member at index `s, s+1, ...` with wrap to 0, where `s = lfsr mod FRAMES`.
- R6: The LFSR is 16 bits wide and loads 16'hACE1 at reset. On every clock after reset it shifts right once, and when the bit shifted out is 1 it then XORs in 16'hB400.
- R7: `clr_tick` clears every referenced bit and leaves every modified bit unchanged. A load, read or write in the same cycle is applied after the clear, so it takes effect.
- R8: `vic_vld` and `vic_idx` answer the request of the previous cycle. `vic_vld` is high for exactly one cycle per request, including back-to-back requests.
- R9: `none_res` is 1 exactly while no frame is present. A request made then gives `vic_vld` = 0.
- R10: A frame that is not present is never chosen as victim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_rd | input | 1 | Read access strobe for `frame_idx` |
| acc_wr | input | 1 | Write access strobe for `frame_idx` |
| frame_ld | input | 1 | Frame load strobe for `frame_idx` |
| frame_idx | input | IDX_W | Frame addressed by access or load |
| clr_tick | input | 1 | Periodic referenced-bit clear |
| vic_req | input | 1 | Victim request |
| vic_idx | output | IDX_W | Chosen victim frame |
| vic_vld | output | 1 | Victim answer valid |
| none_res | output | 1 | No frame is present |

## Verification
The bench builds class mixes in which the expected victim is fixed by class alone. A design that ranked the modified bit above the referenced bit, or that treated a referenced-but-clean frame as cheaper than a dirty unreferenced one, would then name the wrong frame. It issues a tick in the same cycle as a read, and a load in the same cycle as a write. A selector that let the clear win, or let the write dirty a freshly loaded frame, picks a frame from a different class. With only some frames present and all tied in class 0, repeated requests cover many LFSR start points. These expose a wrap-around search that strays onto absent frames or that is off by one from the start index. The empty case and back-to-back requests catch a valid flag raised with nothing resident or stretched beyond one cycle.

// File: rtl/nru_pkg.sv
package nru_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_REPLY = 1'b1
    } sel_state_e;

    localparam int          LFSR_W    = 16;
    localparam logic [15:0] LFSR_SEED = 16'hACE1;
    localparam logic [15:0] LFSR_TAPS = 16'hB400;

    function automatic logic [15:0] lfsr_step(input logic [15:0] cur);
        logic [15:0] nxt;
        nxt = cur >> 1;
        if (cur[0]) nxt = nxt ^ LFSR_TAPS;
        return nxt;
    endfunction

endpackage

// File: rtl/nru_lfsr.sv
module nru_lfsr
    import nru_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    output logic [LFSR_W-1:0] lfsr
);

    always_ff @(posedge clk) begin
        if (!rst_n) lfsr <= LFSR_SEED;
        else        lfsr <= lfsr_step(lfsr);
    end

endmodule

// File: rtl/nru_frame_bits.sv
module nru_frame_bits #(
    parameter int FRAMES = 8,
    localparam int IDX_W = $clog2(FRAMES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic              frame_ld,
    input  logic [IDX_W-1:0]  frame_idx,
    input  logic              clr_tick,
    output logic [FRAMES-1:0] present,
    output logic [FRAMES-1:0] refd,
    output logic [FRAMES-1:0] modf
);

    for (genvar f = 0; f < FRAMES; f++) begin : g_frame
        logic hit;
        assign hit = (frame_idx == IDX_W'(f));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                present[f] <= 1'b0;
                refd[f]    <= 1'b0;
                modf[f]    <= 1'b0;
            end else begin
                if (hit && (frame_ld || acc_wr || acc_rd)) refd[f] <= 1'b1;
                else if (clr_tick)                         refd[f] <= 1'b0;

                if (hit && frame_ld)    modf[f] <= 1'b0;
                else if (hit && acc_wr) modf[f] <= 1'b1;

                if (hit && frame_ld) present[f] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/nru_pick.sv
module nru_pick #(
    parameter int FRAMES = 8,
    localparam int IDX_W = $clog2(FRAMES)
) (
    input  logic [FRAMES-1:0] present,
    input  logic [FRAMES-1:0] refd,
    input  logic [FRAMES-1:0] modf,
    input  logic [IDX_W-1:0]  start,
    output logic              found,
    output logic [IDX_W-1:0]  pick_idx
);

    logic [3:0][FRAMES-1:0] cls_mask;
    logic [FRAMES-1:0]      target;

    for (genvar f = 0; f < FRAMES; f++) begin : g_cls
        for (genvar c = 0; c < 4; c++) begin : g_c
            assign cls_mask[c][f] = present[f] && ({refd[f], modf[f]} == 2'(c));
        end
    end

    always_comb begin
        target = '0;
        for (int c = 3; c >= 0; c--) begin
            if (|cls_mask[c]) target = cls_mask[c];
        end
    end

    always_comb begin
        found    = 1'b0;
        pick_idx = '0;
        for (int k = 0; k < FRAMES; k++) begin
            int j;
            j = (int'(start) + k) % FRAMES;
            if (!found && target[j]) begin
                found    = 1'b1;
                pick_idx = IDX_W'(j);
            end
        end
    end

endmodule

// File: rtl/nru_victim_sel.sv
module nru_victim_sel
    import nru_pkg::*;
#(
    parameter int FRAMES = 8,
    localparam int IDX_W = $clog2(FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_rd,
    input  logic             acc_wr,
    input  logic             frame_ld,
    input  logic [IDX_W-1:0] frame_idx,
    input  logic             clr_tick,
    input  logic             vic_req,
    output logic [IDX_W-1:0] vic_idx,
    output logic             vic_vld,
    output logic             none_res
);

    logic [LFSR_W-1:0] lfsr;
    logic [FRAMES-1:0] present, refd, modf;
    logic [IDX_W-1:0]  start, pick_idx;
    logic              found, found_q;
    sel_state_e        state, state_nxt;

    nru_lfsr u_lfsr (.clk(clk), .rst_n(rst_n), .lfsr(lfsr));

    nru_frame_bits #(.FRAMES(FRAMES)) u_bits (
        .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(acc_wr),
        .frame_ld(frame_ld), .frame_idx(frame_idx), .clr_tick(clr_tick),
        .present(present), .refd(refd), .modf(modf)
    );

    assign start = IDX_W'(lfsr % LFSR_W'(FRAMES));

    nru_pick #(.FRAMES(FRAMES)) u_pick (
        .present(present), .refd(refd), .modf(modf), .start(start),
        .found(found), .pick_idx(pick_idx)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // transitions: REQ_ACCEPT, REQ_AGAIN, REPLY_DONE
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (vic_req) state_nxt = ST_REPLY;
            ST_REPLY: state_nxt = vic_req ? ST_REPLY : ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    // registered answer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vic_idx <= '0;
            found_q <= 1'b0;
        end else if (vic_req) begin
            vic_idx <= pick_idx;
            found_q <= found;
        end
    end

    assign vic_vld  = (state == ST_REPLY) && found_q;
    assign none_res = ~|present;

endmodule

// File: rtl/nru_victim_sel_chk.sv
module nru_victim_sel_chk #(
    parameter int FRAMES = 8,
    localparam int IDX_W = $clog2(FRAMES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_rd,
    input logic              acc_wr,
    input logic              frame_ld,
    input logic              clr_tick,
    input logic              vic_req,
    input logic [IDX_W-1:0]  vic_idx,
    input logic              vic_vld,
    input logic              none_res,
    input logic [FRAMES-1:0] present,
    input logic [FRAMES-1:0] refd,
    input logic [FRAMES-1:0] modf
);

    AST_VLD_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        vic_vld |-> $past(vic_req)); // R8

    AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (vic_req && !none_res) |=> vic_vld); // R8

    AST_EMPTY_NO_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        (vic_req && none_res) |=> !vic_vld); // R9

    AST_VICTIM_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        vic_vld |-> present[vic_idx]); // R10

    AST_TICK_CLEARS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_tick && !acc_rd && !acc_wr && !frame_ld) |=> (refd == '0)); // R7

    AST_TICK_KEEPS_MOD: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_tick && !acc_wr && !frame_ld) |=> (modf == $past(modf))); // R7

endmodule

bind nru_victim_sel nru_victim_sel_chk #(.FRAMES(FRAMES)) chk_i (
    .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .frame_ld(frame_ld), .clr_tick(clr_tick), .vic_req(vic_req),
    .vic_idx(vic_idx), .vic_vld(vic_vld), .none_res(none_res),
    .present(present), .refd(refd), .modf(modf)
);

// File: tb/nru_victim_sel_tb.sv
module nru_victim_sel_tb_top;

    localparam int FRAMES = 8;
    localparam int IDX_W  = $clog2(FRAMES);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             acc_rd = 0, acc_wr = 0, frame_ld = 0, clr_tick = 0, vic_req = 0;
    logic [IDX_W-1:0] frame_idx = '0;
    logic [IDX_W-1:0] vic_idx;
    logic             vic_vld, none_res;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    bit bp [FRAMES];
    bit br [FRAMES];
    bit bm [FRAMES];
    logic [15:0] m_lfsr;

    always #10 clk = ~clk;

    nru_victim_sel #(.FRAMES(FRAMES)) dut_i (
        .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(acc_wr),
        .frame_ld(frame_ld), .frame_idx(frame_idx), .clr_tick(clr_tick),
        .vic_req(vic_req), .vic_idx(vic_idx), .vic_vld(vic_vld),
        .none_res(none_res)
    );

    // R6 generator model
    always_ff @(posedge clk) begin
        if (!rst_n) m_lfsr <= 16'hACE1;
        else        m_lfsr <= m_lfsr[0] ? ((m_lfsr >> 1) ^ 16'hB400) : (m_lfsr >> 1);
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_pick(input int s);
        for (int c = 0; c < 4; c++) begin
            for (int k = 0; k < FRAMES; k++) begin
                int j;
                j = (s + k) % FRAMES;
                if (bp[j] && ((int'(br[j]) * 2 + int'(bm[j])) == c)) return j;
            end
        end
        return -1;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        for (int f = 0; f < FRAMES; f++) begin bp[f] = 0; br[f] = 0; bm[f] = 0; end
    endtask

    // one cycle of stimulus; bench bookkeeping follows R2, R3, R7
    task automatic op(input bit rd, input bit wr, input bit ld, input bit tk, input int idx);
        @(negedge clk);
        acc_rd = rd; acc_wr = wr; frame_ld = ld; clr_tick = tk;
        frame_idx = IDX_W'(idx);
        if (tk) for (int f = 0; f < FRAMES; f++) br[f] = 0;
        if (ld)      begin bp[idx] = 1; br[idx] = 1; bm[idx] = 0; end
        else if (wr) begin br[idx] = 1; bm[idx] = 1; end
        else if (rd) br[idx] = 1;
        @(negedge clk);
        acc_rd = 0; acc_wr = 0; frame_ld = 0; clr_tick = 0;
    endtask

    // request at a negedge, answer sampled on the next negedge
    task automatic request(input string tag, output int got);
        int e;
        @(negedge clk);
        e = exp_pick(int'(m_lfsr % 16'(FRAMES)));
        vic_req = 1;
        @(negedge clk);
        vic_req = 0;
        check({tag, " vld"}, int'(vic_vld), (e >= 0) ? 1 : 0);
        if (e >= 0) check({tag, " idx"}, int'(vic_idx), e);
        got = int'(vic_idx);
    endtask

    task automatic t_reset();
        int g;
        do_reset();
        check("R1 none_res after reset", int'(none_res), 1);
        check("R1 vic_vld after reset", int'(vic_vld), 0);
        request("R9 empty request", g);
        check("R9 vld low when empty", int'(vic_vld), 0);
    endtask

    task automatic t_all_class0();
        int g, e;
        for (int f = 0; f < FRAMES; f++) op(0, 0, 1, 0, f);
        check("R9 none_res low once loaded", int'(none_res), 0);
        op(0, 0, 0, 1, 0);
        for (int n = 0; n < 6; n++) begin
            @(negedge clk);
            e = int'(m_lfsr % 16'(FRAMES));
            vic_req = 1;
            @(negedge clk);
            vic_req = 0;
            check("R5 R6 start index all tied", int'(vic_idx), e);
        end
        g = 0;
    endtask

    task automatic t_classes();
        int g;
        op(0, 0, 0, 1, 0);
        for (int f = 0; f < FRAMES; f++) if (f != 2 && f != 6) op(0, 1, 0, 0, f);
        op(1, 0, 0, 0, 2);
        request("R4 class0 beats others", g);
        check("R4 victim is frame 6", g, 6);
        op(1, 0, 0, 0, 6);
        request("R4 R5 class2 tie", g);
        check("R3 read leaves clean: class2", int'(g == 2 || g == 6), 1);
        op(0, 0, 0, 1, 0);
        request("R7 tick keeps M", g);
        check("R7 clean frames now class0", int'(g == 2 || g == 6), 1);
        op(1, 0, 0, 0, 2);
        op(1, 0, 0, 0, 6);
        request("R4 class1 beats class2", g);
        check("R4 dirty unreferenced chosen", int'(g != 2 && g != 6), 1);
    endtask

    task automatic t_load_priority();
        int g;
        for (int f = 0; f < FRAMES; f++) op(0, 1, 0, 0, f);
        op(0, 1, 1, 0, 3);
        request("R2 load beats write", g);
        check("R2 frame 3 clean class2", g, 3);
    endtask

    task automatic t_tick_with_read();
        int g;
        for (int f = 0; f < FRAMES; f++) op(0, 0, 1, 0, f);
        for (int f = 0; f < FRAMES; f++) if (f != 4) op(0, 1, 0, 0, f);
        op(1, 0, 0, 1, 4);
        request("R7 read same cycle as tick", g);
        check("R7 frame 4 kept R", int'(g != 4), 1);
    endtask

    task automatic t_partial();
        int g;
        do_reset();
        op(0, 0, 1, 0, 1);
        op(0, 0, 1, 0, 5);
        op(0, 0, 0, 1, 0);
        for (int n = 0; n < 10; n++) begin
            request("R10 partial presence", g);
            check("R10 only present frames", int'(g == 1 || g == 5), 1);
        end
    endtask

    task automatic t_pulse();
        int e1, e2;
        @(negedge clk);
        e1 = exp_pick(int'(m_lfsr % 16'(FRAMES)));
        vic_req = 1;
        @(negedge clk);
        e2 = exp_pick(int'(m_lfsr % 16'(FRAMES)));
        check("R8 first of pair vld", int'(vic_vld), 1);
        check("R8 first of pair idx", int'(vic_idx), e1);
        @(negedge clk);
        vic_req = 0;
        check("R8 second of pair vld", int'(vic_vld), 1);
        check("R8 second of pair idx", int'(vic_idx), e2);
        @(negedge clk);
        check("R8 vld drops without request", int'(vic_vld), 0);
    endtask

    initial begin
        t_reset();
        t_all_class0();
        t_classes();
        t_load_priority();
        t_tick_with_read();
        t_partial();
        t_pulse();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule